// File: doc/BRIEF.md
# Quadrature Counter Channel with Byte-Serial Host Access

This block is one channel of a 24-bit up/down position counter fed by a quadrature encoder. The two encoder phases are first passed through two-flop synchronizers. A four-state phase machine then turns each change of the sampled pair into an up step, a down step or an error event. Four decode modes are available: a plain clock-plus-direction mode, and quadrature at one, two or four counts per encoder cycle.

A host reaches the channel over an 8-bit bus with a one-bit address. Address 0 is the data port and address 1 is the control/flag port. The host cannot write the counter directly. It fills a preset register one byte at a time and then issues a transfer command. To read, the host snapshots the live count into an output latch and then reads that latch back one byte at a time. A shared byte pointer selects the byte. Sticky flags report wraps in both directions, a match against the preset, the sign, and phase errors. A live direction bit is reported with them.

The phase machine has states PH_00, PH_10, PH_11 and PH_01, named after the sampled {A,B} pair. The forward transitions are PH_00→PH_10, PH_10→PH_11, PH_11→PH_01 and PH_01→PH_00. The reverse transitions are the same four taken the other way. A diagonal transition (PH_00↔PH_11, PH_10↔PH_01) changes both phases in one sample and is an error. Staying in the same state is idle.

Top module: `qdec_channel`

## Requirements
- R1: After reset the count, the output latch, the byte pointer and every flag are zero. The flag byte reads 0x00 and the mode is non-quadrature.
- R2: A data-port read returns byte [ptr] of the output latch, least significant byte first. Every data-port read or write advances the pointer, and the pointer goes back to 0 after byte 2. Control byte 0x01 puts the pointer back to 0.
- R3: Control byte 0x11 resets the pointer and copies the live count into the output latch. The latch keeps that value while the counter moves.
- R4: A data-port write stores the byte into preset byte [ptr]. Control byte 0x08 copies the preset into the counter. Writing the preset alone leaves the count unchanged.
- R5: A control write with bits 7:5 = 001 sets the decode mode from bits 4:3: 0 is non-quadrature, 1 is x1, 2 is x2 and 3 is x4. Bits 2:1 of that write have no effect. The forward order is A leading B, and it counts up. In x4 every forward or reverse transition counts. In x2 only transitions that change A count. In x1 only PH_00→PH_10 (up) and PH_10→PH_00 (down) count.
- R6: In non-quadrature mode each rising edge of A counts once: up while B is 1 and down while B is 0. A change of B alone never counts.
- R7: A step from 0xFFFFFF up to 0 sets carry (flag bit 1). A step from 0 down to 0xFFFFFF sets borrow (flag bit 0). Both flags stay set until cleared. Borrow XOR carry serves the host as a 25th count bit.
- R8: A counting step that lands on the preset value sets compare (flag bit 2). A counting step that leaves bit 23 of the count set sets sign (flag bit 3). Control byte 0x02 clears flag bits 0 to 3.
- R9: In any quadrature mode, a sample in which A and B both change sets error (flag bit 4) and makes no count. Only control byte 0x06 clears error.
- R10: Flag bit 5 reads 1 after a forward transition and 0 after a reverse one in quadrature modes. In non-quadrature mode it follows the level of B. Flag bits 7:6 read 0.
- R11: A control write with bits 7:5 = 011 changes neither the count, the flags nor the byte pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_addr | input | 1 | 0 selects the data port, 1 selects the control/flag port |
| host_wr | input | 1 | Write strobe, one cycle per access |
| host_rd | input | 1 | Read strobe, one cycle per access; advances the pointer on the data port |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data: a latch byte or the flag byte, valid in the strobe cycle |
| phase_a | input | 1 | Encoder phase A, asynchronous |
| phase_b | input | 1 | Encoder phase B, asynchronous |

## Verification
The bench builds the channel with its defaults: a 24-bit count and two synchronizer stages. This makes both wrap boundaries reachable in a few steps, because the counter can be preset next to 0xFFFFFF or 0. The bench sweeps all four decode modes through a full forward and reverse pass over the phase machine. It also walks a set of computed preset values through the load-and-read path, so all three byte lanes and the pointer wrap are covered. Expected counts come from the number of encoder cycles multiplied by the mode's count rate.

// File: rtl/qdec_pkg.sv
package qdec_pkg;

    // Sampled {A,B} pair doubles as the phase state.
    typedef enum logic [1:0] {
        PH_00 = 2'b00,
        PH_01 = 2'b01,
        PH_10 = 2'b10,
        PH_11 = 2'b11
    } phase_t;

    typedef enum logic [1:0] {
        QM_NONE = 2'd0,
        QM_X1   = 2'd1,
        QM_X2   = 2'd2,
        QM_X4   = 2'd3
    } qmode_t;

    // Control-write groups, selected by bits 7:5.
    localparam logic [2:0] GRP_CMD  = 3'b000;
    localparam logic [2:0] GRP_MODE = 3'b001;

    // Flag byte bit positions.
    localparam int FL_BORROW = 0;
    localparam int FL_CARRY  = 1;
    localparam int FL_CMP    = 2;
    localparam int FL_SIGN   = 3;
    localparam int FL_ERR    = 4;
    localparam int FL_UP     = 5;

endpackage

// File: rtl/qdec_sync.sv
module qdec_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    localparam int CHAIN_W = W * STAGES;

    logic [CHAIN_W-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[CHAIN_W-W-1:0], d};
            end
        end
    endgenerate

    assign q = chain_q[CHAIN_W-1 -: W];

endmodule

// File: rtl/qdec_phase_fsm.sv
module qdec_phase_fsm
    import qdec_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] ab_now,
    input  qmode_t     mode,
    output logic       step_up,
    output logic       step_dn,
    output logic       err_evt,
    output logic       dir_up
);
    phase_t state_q;
    phase_t state_d;
    logic   fwd;
    logic   rev;
    logic   a_chg;
    logic   b_chg;
    logic   a_rise;

    assign state_d = phase_t'(ab_now);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_00;
        else        state_q <= state_d;
    end

    // Transition classification and step outputs
    always_comb begin
        fwd = 1'b0;
        rev = 1'b0;
        unique case (state_q)
            PH_00: begin
                fwd = (ab_now == 2'b10);
                rev = (ab_now == 2'b01);
            end
            PH_10: begin
                fwd = (ab_now == 2'b11);
                rev = (ab_now == 2'b00);
            end
            PH_11: begin
                fwd = (ab_now == 2'b01);
                rev = (ab_now == 2'b10);
            end
            PH_01: begin
                fwd = (ab_now == 2'b00);
                rev = (ab_now == 2'b11);
            end
        endcase

        a_chg  = ab_now[1] ^ state_q[1];
        b_chg  = ab_now[0] ^ state_q[0];
        a_rise = ab_now[1] & ~state_q[1];

        step_up = 1'b0;
        step_dn = 1'b0;
        err_evt = 1'b0;
        unique case (mode)
            QM_NONE: begin
                step_up = a_rise &  ab_now[0];
                step_dn = a_rise & ~ab_now[0];
            end
            QM_X1: begin
                step_up = (state_q == PH_00) && (ab_now == 2'b10);
                step_dn = (state_q == PH_10) && (ab_now == 2'b00);
                err_evt = a_chg & b_chg;
            end
            QM_X2: begin
                step_up = fwd & a_chg;
                step_dn = rev & a_chg;
                err_evt = a_chg & b_chg;
            end
            QM_X4: begin
                step_up = fwd;
                step_dn = rev;
                err_evt = a_chg & b_chg;
            end
        endcase
    end

    // Direction indication
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                dir_up <= 1'b0;
        else if (mode == QM_NONE)  dir_up <= ab_now[0];
        else if (fwd)              dir_up <= 1'b1;
        else if (rev)              dir_up <= 1'b0;
    end

endmodule

// File: rtl/qdec_count_core.sv
module qdec_count_core #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_up,
    input  logic             step_dn,
    input  logic             err_evt,
    input  logic             load,
    input  logic             clr_bcs,
    input  logic             clr_err,
    input  logic [CNT_W-1:0] preset,
    output logic [CNT_W-1:0] cnt_q,
    output logic             borrow_q,
    output logic             carry_q,
    output logic             cmp_q,
    output logic             sign_q,
    output logic             error_q
);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] CNT_ZERO = '0;
    localparam logic [CNT_W-1:0] CNT_ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_d;
    logic             moving;
    logic             wrap_up;
    logic             wrap_dn;

    always_comb begin
        cnt_d  = cnt_q;
        moving = 1'b0;
        if (load) begin
            cnt_d = preset;
        end else if (step_up) begin
            cnt_d  = cnt_q + CNT_ONE;
            moving = 1'b1;
        end else if (step_dn) begin
            cnt_d  = cnt_q - CNT_ONE;
            moving = 1'b1;
        end
    end

    assign wrap_up = !load && step_up && (cnt_q == CNT_MAX);
    assign wrap_dn = !load && !step_up && step_dn && (cnt_q == CNT_ZERO);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            borrow_q <= 1'b0;
            carry_q  <= 1'b0;
            cmp_q    <= 1'b0;
            sign_q   <= 1'b0;
            error_q  <= 1'b0;
        end else begin
            cnt_q    <= cnt_d;
            borrow_q <= (borrow_q & ~clr_bcs) | wrap_dn;
            carry_q  <= (carry_q  & ~clr_bcs) | wrap_up;
            cmp_q    <= (cmp_q    & ~clr_bcs) | (moving && (cnt_d == preset));
            sign_q   <= (sign_q   & ~clr_bcs) | (moving && cnt_d[CNT_W-1]);
            error_q  <= (error_q  & ~clr_err) | err_evt;
        end
    end

endmodule

// File: rtl/qdec_hostif.sv
module qdec_hostif
    import qdec_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             addr,
    input  logic             wr,
    input  logic             rd,
    input  logic [7:0]       wdata,
    input  logic [CNT_W-1:0] cnt,
    input  logic [7:0]       flags,
    output logic [7:0]       rdata,
    output logic [CNT_W-1:0] preset_q,
    output logic [CNT_W-1:0] latch_q,
    output qmode_t           mode_q,
    output logic             load_cmd,
    output logic             latch_cmd,
    output logic             clr_bcs,
    output logic             clr_err
);
    localparam int NB = CNT_W / 8;
    localparam int PW = (NB > 1) ? $clog2(NB) : 1;
    localparam logic [PW-1:0] PTR_LAST = PW'(NB - 1);

    logic [PW-1:0] ptr_q;
    logic          data_wr;
    logic          data_rd;
    logic          cmd_wr;
    logic          mode_wr;
    logic          ptr_rst;
    logic [7:0]    lat_byte;

    assign data_wr   = wr & ~addr;
    assign data_rd   = rd & ~addr;
    assign cmd_wr    = wr & addr & (wdata[7:5] == GRP_CMD);
    assign mode_wr   = wr & addr & (wdata[7:5] == GRP_MODE);
    assign ptr_rst   = cmd_wr & wdata[0];
    assign latch_cmd = cmd_wr & wdata[4];
    assign load_cmd  = cmd_wr & wdata[3];
    assign clr_bcs   = cmd_wr & (wdata[2:1] == 2'b01);
    assign clr_err   = cmd_wr & (wdata[2:1] == 2'b11);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q    <= '0;
            preset_q <= '0;
            latch_q  <= '0;
            mode_q   <= QM_NONE;
        end else begin
            if (ptr_rst)
                ptr_q <= '0;
            else if (data_wr || data_rd)
                ptr_q <= (ptr_q == PTR_LAST) ? '0 : ptr_q + PW'(1);
            if (data_wr) begin
                for (int b = 0; b < NB; b++)
                    if (ptr_q == PW'(b)) preset_q[b*8 +: 8] <= wdata;
            end
            if (latch_cmd) latch_q <= cnt;
            if (mode_wr)   mode_q  <= qmode_t'(wdata[4:3]);
        end
    end

    always_comb begin
        lat_byte = 8'h00;
        for (int b = 0; b < NB; b++)
            if (ptr_q == PW'(b)) lat_byte = latch_q[b*8 +: 8];
        rdata = addr ? flags : lat_byte;
    end

endmodule

// File: rtl/qdec_channel.sv
module qdec_channel
    import qdec_pkg::*;
#(
    parameter int CNT_W       = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_addr,
    input  logic       host_wr,
    input  logic       host_rd,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    input  logic       phase_a,
    input  logic       phase_b
);
    logic [1:0]       ab_sync;
    qmode_t           mode_q;
    logic             step_up;
    logic             step_dn;
    logic             err_evt;
    logic             dir_up;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] preset_q;
    logic [CNT_W-1:0] latch_q;
    logic             load_cmd;
    logic             latch_cmd;
    logic             clr_bcs;
    logic             clr_err;
    logic             borrow_f;
    logic             carry_f;
    logic             cmp_f;
    logic             sign_f;
    logic             error_f;
    logic [7:0]       flag_byte;

    qdec_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({phase_a, phase_b}),
        .q     (ab_sync)
    );

    qdec_phase_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .ab_now  (ab_sync),
        .mode    (mode_q),
        .step_up (step_up),
        .step_dn (step_dn),
        .err_evt (err_evt),
        .dir_up  (dir_up)
    );

    qdec_count_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_up  (step_up),
        .step_dn  (step_dn),
        .err_evt  (err_evt),
        .load     (load_cmd),
        .clr_bcs  (clr_bcs),
        .clr_err  (clr_err),
        .preset   (preset_q),
        .cnt_q    (cnt_q),
        .borrow_q (borrow_f),
        .carry_q  (carry_f),
        .cmp_q    (cmp_f),
        .sign_q   (sign_f),
        .error_q  (error_f)
    );

    always_comb begin
        flag_byte            = 8'h00;
        flag_byte[FL_BORROW] = borrow_f;
        flag_byte[FL_CARRY]  = carry_f;
        flag_byte[FL_CMP]    = cmp_f;
        flag_byte[FL_SIGN]   = sign_f;
        flag_byte[FL_ERR]    = error_f;
        flag_byte[FL_UP]     = dir_up;
    end

    qdec_hostif #(.CNT_W(CNT_W)) u_host (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (host_addr),
        .wr        (host_wr),
        .rd        (host_rd),
        .wdata     (host_wdata),
        .cnt       (cnt_q),
        .flags     (flag_byte),
        .rdata     (host_rdata),
        .preset_q  (preset_q),
        .latch_q   (latch_q),
        .mode_q    (mode_q),
        .load_cmd  (load_cmd),
        .latch_cmd (latch_cmd),
        .clr_bcs   (clr_bcs),
        .clr_err   (clr_err)
    );

endmodule

// File: rtl/qdec_channel_chk.sv
module qdec_channel_chk #(
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] latch_q,
    input logic             carry_f,
    input logic             borrow_f,
    input logic             error_f,
    input logic             load_cmd,
    input logic             latch_cmd,
    input logic             clr_err,
    input logic             step_up,
    input logic             step_dn,
    input logic             err_evt
);
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    // R7
    carry_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(carry_f) |-> (cnt_q == '0));

    // R7
    borrow_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(borrow_f) |-> (cnt_q == '1));

    // R9
    err_no_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_evt && !load_cmd) |=> $stable(cnt_q));

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (error_f && !clr_err) |=> error_f);

    // R5
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_cmd |=> ((cnt_q == $past(cnt_q)) ||
                       (cnt_q == $past(cnt_q) + CNT_ONE) ||
                       (cnt_q == $past(cnt_q) - CNT_ONE)));

    // R5
    step_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({step_up, step_dn, err_evt}));

    // R3
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_cmd |=> $stable(latch_q));

endmodule

bind qdec_channel qdec_channel_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_q     (cnt_q),
    .latch_q   (latch_q),
    .carry_f   (carry_f),
    .borrow_f  (borrow_f),
    .error_f   (error_f),
    .load_cmd  (load_cmd),
    .latch_cmd (latch_cmd),
    .clr_err   (clr_err),
    .step_up   (step_up),
    .step_dn   (step_dn),
    .err_evt   (err_evt)
);

// File: tb/test_qdec_channel.sv
module test_qdec_channel;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_addr = 1'b0;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic       phase_a = 1'b0;
    logic       phase_b = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;
    int ph_idx   = 0;
    bit done     = 1'b0;

    logic [1:0] seq [4] = '{2'b00, 2'b10, 2'b11, 2'b01};

    qdec_channel i_qdec_channel (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_addr  (host_addr),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .phase_a    (phase_a),
        .phase_b    (phase_b)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic host_read(input logic a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic load_count(input logic [23:0] v);
        host_write(1'b1, 8'h01);
        for (int i = 0; i < 3; i++) host_write(1'b0, v[i*8 +: 8]);
        host_write(1'b1, 8'h08);
    endtask

    task automatic write_preset(input logic [23:0] v);
        host_write(1'b1, 8'h01);
        for (int i = 0; i < 3; i++) host_write(1'b0, v[i*8 +: 8]);
    endtask

    task automatic read_count(output logic [23:0] v);
        logic [7:0] b;
        host_write(1'b1, 8'h11);
        for (int i = 0; i < 3; i++) begin
            host_read(1'b0, b);
            v[i*8 +: 8] = b;
        end
    endtask

    task automatic read_flags(output logic [7:0] f);
        host_read(1'b1, f);
    endtask

    task automatic set_ab(input logic a, input logic b);
        @(negedge clk);
        phase_a = a; phase_b = b;
        repeat (5) @(negedge clk);
    endtask

    task automatic step_fwd(input int n);
        for (int i = 0; i < n; i++) begin
            ph_idx = (ph_idx + 1) % 4;
            set_ab(seq[ph_idx][1], seq[ph_idx][0]);
        end
    endtask

    task automatic step_rev(input int n);
        for (int i = 0; i < n; i++) begin
            ph_idx = (ph_idx + 3) % 4;
            set_ab(seq[ph_idx][1], seq[ph_idx][0]);
        end
    endtask

    task automatic finish_run;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [23:0] cnt;
        logic [7:0]  fl;
        logic [7:0]  b;
        logic [23:0] v;
        int          mult;
        int          base;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: reset state
        read_flags(fl);
        check("R1 flags", fl, 8'h00);
        host_read(1'b0, b);
        check("R1 latch byte0", b, 0);
        read_count(cnt);
        check("R1 count", cnt, 0);

        // R4 / R2: load, byte order and pointer wrap
        load_count(24'hA1B2C3);
        host_write(1'b1, 8'h11);
        host_read(1'b0, b); check("R2 byte0", b, 8'hC3);
        host_read(1'b0, b); check("R2 byte1", b, 8'hB2);
        host_read(1'b0, b); check("R2 byte2", b, 8'hA1);
        host_read(1'b0, b); check("R2 wrap", b, 8'hC3);
        host_read(1'b0, b);
        host_write(1'b1, 8'h01);
        host_read(1'b0, b); check("R2 ptr reset", b, 8'hC3);

        // R4: preset alone does not move the count
        write_preset(24'h010203);
        read_count(cnt);
        check("R4 preset only", cnt, 24'hA1B2C3);

        // R4: sweep of computed preset values
        for (int i = 0; i < 8; i++) begin
            v = 24'(i * 24'h2F1A3B) ^ 24'h5A5A5A;
            load_count(v);
            read_count(cnt);
            check("R4 load sweep", cnt, v);
        end

        // R5 / R10 / R3: quadrature mode sweep
        for (int m = 1; m < 4; m++) begin
            mult = (m == 1) ? 1 : (m == 2) ? 2 : 4;
            host_write(1'b1, 8'h20 | 8'(m << 3) | 8'h06);
            base = 24'h000100;
            load_count(24'(base));
            step_fwd(8);
            read_count(cnt);
            check("R5 forward", cnt, base + 2 * mult);
            read_flags(fl);
            check("R10 dir up", fl[5], 1);
            step_rev(12);
            host_write(1'b1, 8'h01);
            for (int i = 0; i < 3; i++) begin
                host_read(1'b0, b);
                cnt[i*8 +: 8] = b;
            end
            check("R3 latch holds", cnt, base + 2 * mult);
            read_count(cnt);
            check("R5 reverse", cnt, base + 2 * mult - 3 * mult);
            read_flags(fl);
            check("R10 dir down", fl[5], 0);
        end

        // R6: non-quadrature clock plus direction
        host_write(1'b1, 8'h20);
        load_count(24'h000050);
        set_ab(1'b0, 1'b1);
        read_count(cnt);
        check("R6 B alone", cnt, 24'h50);
        for (int i = 0; i < 5; i++) begin
            set_ab(1'b1, 1'b1);
            set_ab(1'b0, 1'b1);
        end
        read_count(cnt);
        check("R6 up", cnt, 24'h55);
        read_flags(fl);
        check("R10 nonquad dir B high", fl[5], 1);
        set_ab(1'b0, 1'b0);
        for (int i = 0; i < 3; i++) begin
            set_ab(1'b1, 1'b0);
            set_ab(1'b0, 1'b0);
        end
        read_count(cnt);
        check("R6 down", cnt, 24'h52);
        read_flags(fl);
        check("R10 nonquad dir B low", fl[5], 0);
        ph_idx = 0;

        // R7: wraps in x4
        host_write(1'b1, 8'h38);
        load_count(24'hFFFFFE);
        host_write(1'b1, 8'h02);
        step_fwd(3);
        read_count(cnt);
        check("R7 up wrap count", cnt, 24'h000001);
        read_flags(fl);
        check("R7 carry only", fl[1:0], 2'b10);
        check("R7 25th bit after carry", fl[0] ^ fl[1], 1);
        step_fwd(1);
        host_write(1'b1, 8'h02);
        read_flags(fl);
        check("R8 clear", fl[3:0], 0);
        load_count(24'h000001);
        step_rev(4);
        read_count(cnt);
        check("R7 down wrap count", cnt, 24'hFFFFFD);
        read_flags(fl);
        check("R7 borrow only", fl[1:0], 2'b01);
        check("R8 sign", fl[3], 1);
        load_count(24'hFFFFFF);
        step_fwd(4);
        read_flags(fl);
        check("R7 both set", fl[1:0], 2'b11);
        check("R7 25th bit cancels", fl[0] ^ fl[1], 0);
        host_write(1'b1, 8'h02);
        read_flags(fl);
        check("R8 clear bits", fl[3:0], 0);

        // R8: compare on landing at preset
        load_count(24'h000010);
        write_preset(24'h000012);
        host_write(1'b1, 8'h02);
        step_fwd(2);
        read_flags(fl);
        check("R8 compare", fl[2], 1);
        check("R8 sign clear", fl[3], 0);
        step_fwd(2);
        read_flags(fl);
        check("R8 compare sticky", fl[2], 1);
        host_write(1'b1, 8'h02);
        read_flags(fl);
        check("R8 compare cleared", fl[2], 0);

        // R11: index-control writes have no effect
        load_count(24'h345678);
        host_write(1'b1, 8'h11);
        host_read(1'b0, b);
        read_flags(fl);
        host_write(1'b1, 8'h62);
        host_write(1'b1, 8'h61);
        host_read(1'b0, b);
        check("R11 pointer", b, 8'h56);
        read_flags(b);
        check("R11 flags", b, fl);
        read_count(cnt);
        check("R11 count", cnt, 24'h345678);

        // R9: phase error
        host_write(1'b1, 8'h06);
        set_ab(1'b1, 1'b1);
        read_count(cnt);
        check("R9 no count", cnt, 24'h345678);
        read_flags(fl);
        check("R9 error set", fl[4], 1);
        set_ab(1'b0, 1'b0);
        host_write(1'b1, 8'h02);
        read_flags(fl);
        check("R9 survives 0x02", fl[4], 1);
        read_count(cnt);
        check("R9 count still", cnt, 24'h345678);
        host_write(1'b1, 8'h06);
        read_flags(fl);
        check("R9 cleared by 0x06", fl[4], 0);

        done = 1'b1;
        finish_run();
    end

endmodule